// File: doc/BRIEF.md
# ACPI Power-Management Event and SCI Logic

This block is the event half of a power-management function. It holds three 16-bit registers (event status, event enable and PM control) that software reaches through a 64-byte I/O window. The base and the on/off switch of that window come from configuration-space values supplied by the surrounding function. Four hardware event pulses set sticky status bits: timer overflow, global-lock release, power button and RTC alarm. Software clears a status bit by writing a 1 to it.

Status and enable combine into a level-sensitive system control interrupt (SCI). The SCI is high while any of the four event sources has both its status and its enable bit set. The block also drives a timer-arm output. A free-running PM timer uses it to decide whether its next overflow should be reported. The arm output is high only while the timer event is enabled and its status has not yet been latched.

Top module: `pm_event_sci`

## Requirements
- R1: After reset the status, enable and control registers read 0, and `sci` and `tmr_arm` are low.
- R2: A one-cycle pulse on an event input sets its status bit at the next clock edge, and the bit then stays set. The bit positions, the same in status and enable, are timer bit 0, global lock bit 5, power button bit 8 and RTC bit 10. No other status bit can ever become 1.
- R3: A write to the status register (window offset 0x00) clears every bit written as 1 and leaves every bit written as 0 unchanged. An event pulse in the same cycle as a clear of its bit leaves the bit set.
- R4: The enable register (offset 0x02) and the control register (offset 0x04) store all 16 written bits and read them back. A register is selected by address bits [5:1], so an odd address reaches the same register as the even address below it. Offsets from 0x06 to 0x3F read 0 and ignore writes.
- R5: `sci` equals the OR of (status AND enable AND mask), where the mask holds bits 0, 5, 8 and 10 only. It rises in the cycle after an enabled event pulse and falls in the cycle after the write that clears the last enabled pending status.
- R6: `tmr_arm` is 1 exactly when enable bit 0 is 1 and status bit 0 is 0.
- R7: The window base is the configuration word ANDed with 0xFFC0. Bits 31:16 and 5:0 of the word play no part. The window spans the 64 byte addresses starting at that base.
- R8: `hit` is high only during a read or write whose address lies in the window while bit 0 of the configuration enable byte is 1. When that bit is 0, a write changes no register.
- R9: `bus_rdata` is 0 whenever the cycle is not a read hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_word | input | 32 | Configuration word that holds the window base |
| cfg_enable_byte | input | 8 | Configuration byte; bit 0 turns the window on |
| bus_addr | input | 16 | I/O byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as a read hit |
| evt_tmr | input | 1 | Timer overflow pulse |
| evt_glbl | input | 1 | Global lock release pulse |
| evt_pwrbtn | input | 1 | Power button pulse |
| evt_rtc | input | 1 | RTC alarm pulse |
| hit | output | 1 | Access decoded inside the enabled window |
| sci | output | 1 | Level SCI |
| tmr_arm | output | 1 | Arm request to the PM timer overflow logic |

## Verification
The bench builds the block with its default parameters: a 16-bit address and data path and a 64-byte window. These defaults bring every window offset and every implemented status and enable bit within reach of random stimulus. They also bring the window comparison against a full 16-bit address into reach, so bases near both ends of the I/O space and addresses just outside the window can be exercised. The random phase moves the base and toggles the window switch between bursts. This covers the case of an event arriving in the same cycle as a clear, and the case of writes landing while the window is off.

// File: rtl/pm_evt_pkg.sv
`timescale 1ns/1ps
package pm_evt_pkg;
    localparam int unsigned REG_W   = 16;
    localparam int unsigned TMR_BIT = 0;
    localparam int unsigned GLB_BIT = 5;
    localparam int unsigned PWR_BIT = 8;
    localparam int unsigned RTC_BIT = 10;

    localparam logic [REG_W-1:0] SCI_MASK =
        (REG_W'(1) << TMR_BIT) | (REG_W'(1) << GLB_BIT) |
        (REG_W'(1) << PWR_BIT) | (REG_W'(1) << RTC_BIT);

    typedef enum logic [1:0] {
        SEL_STS  = 2'd0,
        SEL_EN   = 2'd1,
        SEL_CTL  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pm_win_decode.sv
`timescale 1ns/1ps
module pm_win_decode
    import pm_evt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned WIN_BYTES = 64
) (
    input  logic [31:0]       cfg_base_word,
    input  logic [7:0]        cfg_enable_byte,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic              hit,
    output reg_sel_e          sel
);
    localparam int unsigned OFS_W = $clog2(WIN_BYTES);
    localparam int unsigned IDX_W = OFS_W - 1;

    logic             base_match;
    logic [IDX_W-1:0] word_idx;
    logic             unused_cfg;

    // Window base is the word masked down to a WIN_BYTES boundary.
    assign base_match = (bus_addr[ADDR_W-1:OFS_W] == cfg_base_word[ADDR_W-1:OFS_W]);
    assign hit        = cfg_enable_byte[0] & (bus_rd | bus_wr) & base_match;
    assign word_idx   = bus_addr[OFS_W-1:1];
    assign unused_cfg = ^{cfg_base_word[31:ADDR_W], cfg_base_word[OFS_W-1:0],
                          cfg_enable_byte[7:1], bus_addr[0]};

    always_comb begin
        unique case (word_idx)
            IDX_W'(0): sel = SEL_STS;
            IDX_W'(1): sel = SEL_EN;
            IDX_W'(2): sel = SEL_CTL;
            default:   sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/pm_evt_regs.sv
`timescale 1ns/1ps
module pm_evt_regs
    import pm_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sts,
    input  logic             wr_en,
    input  logic             wr_ctl,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] evt_vec,
    output logic [REG_W-1:0] sts_q,
    output logic [REG_W-1:0] en_q,
    output logic [REG_W-1:0] ctl_q
);
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] sts_d;

    assign clr_vec = wr_sts ? wdata : '0;

    // Set has priority over write-one-to-clear on the same bit.
    genvar b;
    generate
        for (b = 0; b < REG_W; b++) begin : g_sts_bit
            if (SCI_MASK[b]) begin : g_impl
                assign sts_d[b] = evt_vec[b] | (sts_q[b] & ~clr_vec[b]);
            end else begin : g_zero
                assign sts_d[b] = 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
            en_q  <= '0;
            ctl_q <= '0;
        end else begin
            sts_q <= sts_d;
            if (wr_en)  en_q  <= wdata;
            if (wr_ctl) ctl_q <= wdata;
        end
    end
endmodule

// File: rtl/pm_sci_gen.sv
`timescale 1ns/1ps
module pm_sci_gen
    import pm_evt_pkg::*;
(
    input  logic [REG_W-1:0] sts_q,
    input  logic [REG_W-1:0] en_q,
    output logic             sci,
    output logic             tmr_arm
);
    assign sci     = |(sts_q & en_q & SCI_MASK);
    assign tmr_arm = en_q[TMR_BIT] & ~sts_q[TMR_BIT];
endmodule

// File: rtl/pm_event_sci.sv
`timescale 1ns/1ps
module pm_event_sci
    import pm_evt_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned WIN_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_base_word,
    input  logic [7:0]        cfg_enable_byte,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              evt_tmr,
    input  logic              evt_glbl,
    input  logic              evt_pwrbtn,
    input  logic              evt_rtc,
    output logic              hit,
    output logic              sci,
    output logic              tmr_arm
);
    reg_sel_e         sel;
    logic [REG_W-1:0] sts_q, en_q, ctl_q;
    logic [REG_W-1:0] evt_vec;
    logic             wr_hit;

    always_comb begin
        evt_vec          = '0;
        evt_vec[TMR_BIT] = evt_tmr;
        evt_vec[GLB_BIT] = evt_glbl;
        evt_vec[PWR_BIT] = evt_pwrbtn;
        evt_vec[RTC_BIT] = evt_rtc;
    end

    pm_win_decode #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_dec (
        .cfg_base_word   (cfg_base_word),
        .cfg_enable_byte (cfg_enable_byte),
        .bus_addr        (bus_addr),
        .bus_rd          (bus_rd),
        .bus_wr          (bus_wr),
        .hit             (hit),
        .sel             (sel)
    );

    assign wr_hit = hit & bus_wr;

    pm_evt_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sts  (wr_hit && sel == SEL_STS),
        .wr_en   (wr_hit && sel == SEL_EN),
        .wr_ctl  (wr_hit && sel == SEL_CTL),
        .wdata   (bus_wdata),
        .evt_vec (evt_vec),
        .sts_q   (sts_q),
        .en_q    (en_q),
        .ctl_q   (ctl_q)
    );

    pm_sci_gen u_sci (
        .sts_q   (sts_q),
        .en_q    (en_q),
        .sci     (sci),
        .tmr_arm (tmr_arm)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit && bus_rd) begin
            unique case (sel)
                SEL_STS: bus_rdata = sts_q;
                SEL_EN:  bus_rdata = en_q;
                SEL_CTL: bus_rdata = ctl_q;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pm_event_sci_chk.sv
`timescale 1ns/1ps
module pm_event_sci_chk
    import pm_evt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       cfg_enable_byte,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [REG_W-1:0] bus_rdata,
    input logic             evt_tmr,
    input logic             evt_pwrbtn,
    input logic             hit,
    input logic             sci,
    input logic             tmr_arm,
    input logic [REG_W-1:0] sts_q,
    input logic [REG_W-1:0] en_q
);
    // R2: a timer pulse leaves its status bit set after the edge
    p_tmr_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tmr |=> sts_q[TMR_BIT]);
    p_pwr_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pwrbtn |=> sts_q[PWR_BIT]);
    // R2: status holds without a write
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[TMR_BIT] && !bus_wr) |=> sts_q[TMR_BIT]);
    // R2: unimplemented status bits stay clear
    p_sts_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q & ~SCI_MASK) == '0);
    // R5: nothing enabled means no interrupt
    p_no_en_no_sci_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !sci);
    // R6: a latched timer status keeps the timer disarmed
    p_arm_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sts_q[TMR_BIT] |-> !tmr_arm);
    // R8: decode needs the window switch and a strobe
    p_hit_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (cfg_enable_byte[0] && (bus_rd || bus_wr)));
    // R8: with the window off, enable cannot change
    p_off_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable_byte[0] |=> $stable(en_q));
    // R9: no read hit, no data
    p_rdata_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && bus_rd) |-> (bus_rdata == '0));
endmodule

bind pm_event_sci pm_event_sci_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_enable_byte (cfg_enable_byte),
    .bus_rd          (bus_rd),
    .bus_wr          (bus_wr),
    .bus_rdata       (bus_rdata),
    .evt_tmr         (evt_tmr),
    .evt_pwrbtn      (evt_pwrbtn),
    .hit             (hit),
    .sci             (sci),
    .tmr_arm         (tmr_arm),
    .sts_q           (sts_q),
    .en_q            (en_q)
);

// File: tb/test_pm_event_sci.sv
`timescale 1ns/1ps
module test_pm_event_sci;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base_word = 32'h0;
    logic [7:0]  cfg_enable_byte = 8'h0;
    logic [15:0] bus_addr = 16'h0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        evt_tmr = 1'b0, evt_glbl = 1'b0, evt_pwrbtn = 1'b0, evt_rtc = 1'b0;
    logic        hit, sci, tmr_arm;

    localparam logic [15:0] MASK = 16'h0521;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_sts = 16'h0, m_en = 16'h0, m_ctl = 16'h0;

    always #2.5 clk = ~clk;

    pm_event_sci i_pm_event_sci (
        .clk(clk), .rst_n(rst_n), .cfg_base_word(cfg_base_word),
        .cfg_enable_byte(cfg_enable_byte), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .evt_tmr(evt_tmr), .evt_glbl(evt_glbl),
        .evt_pwrbtn(evt_pwrbtn), .evt_rtc(evt_rtc), .hit(hit), .sci(sci),
        .tmr_arm(tmr_arm)
    );

    function automatic logic [15:0] evt_vec(input logic [3:0] e);
        // e = {rtc, pwrbtn, glbl, tmr}
        evt_vec = 16'h0;
        evt_vec[0]  = e[0];
        evt_vec[5]  = e[1];
        evt_vec[8]  = e[2];
        evt_vec[10] = e[3];
    endfunction

    function automatic logic exp_hit(input logic [15:0] a, input logic act);
        exp_hit = cfg_enable_byte[0] && act && (a[15:6] == cfg_base_word[15:6]);
    endfunction

    function automatic logic [15:0] exp_read(input logic [15:0] a);
        case (a[5:1])
            5'd0:    exp_read = m_sts;
            5'd1:    exp_read = m_en;
            5'd2:    exp_read = m_ctl;
            default: exp_read = 16'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // One bus cycle: drive at negedge, check decode before the edge,
    // update the model at the edge, check registered outputs after it.
    task automatic step(input logic wr, input logic rd, input logic [15:0] a,
                        input logic [15:0] wd, input logic [3:0] e);
        logic eh;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        {evt_rtc, evt_pwrbtn, evt_glbl, evt_tmr} = e;
        #1;
        eh = exp_hit(a, wr | rd);
        chk("R7/R8 hit", {15'h0, hit}, {15'h0, eh});
        chk("R4/R9 rdata", bus_rdata, (eh && rd) ? exp_read(a) : 16'h0);
        @(posedge clk);
        #1;
        if (eh && wr) begin
            case (a[5:1])
                5'd0: m_sts = m_sts & ~wd;
                5'd1: m_en  = wd;
                5'd2: m_ctl = wd;
                default: ;
            endcase
        end
        m_sts = m_sts | evt_vec(e);
        bus_wr = 1'b0; bus_rd = 1'b0;
        {evt_rtc, evt_pwrbtn, evt_glbl, evt_tmr} = 4'h0;
        chk("R5 sci", {15'h0, sci}, {15'h0, |(m_sts & m_en & MASK)});
        chk("R6 tmr_arm", {15'h0, tmr_arm}, {15'h0, m_en[0] & ~m_sts[0]});
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [15:0] exp);
        step(1'b0, 1'b1, a, 16'h0, 4'h0);
        chk(tag, exp_read(a), exp);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] base;
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        repeat (4) @(posedge clk);
        #1;
        chk("R1 sci reset", {15'h0, sci}, 16'h0);
        chk("R1 arm reset", {15'h0, tmr_arm}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: upper word bits and low bits ignored
        cfg_base_word = 32'h1234_ABC7;
        cfg_enable_byte = 8'h01;
        base = 16'hABC0;
        step(1'b0, 1'b1, base, 16'h0, 4'h0);
        chk("R1 status zero", bus_rdata, 16'h0);
        rd_chk("R1 enable zero", base + 16'h2, 16'h0);
        rd_chk("R1 control zero", base + 16'h4, 16'h0);
        step(1'b0, 1'b1, base + 16'h40, 16'h0, 4'h0);  // R7 just above window
        step(1'b0, 1'b1, base - 16'h1, 16'h0, 4'h0);   // R7 just below window

        // R8: window off, write ignored
        cfg_enable_byte = 8'hFE;
        step(1'b1, 1'b0, base + 16'h2, 16'hFFFF, 4'h0);
        cfg_enable_byte = 8'h01;
        rd_chk("R8 ignored write", base + 16'h2, 16'h0);

        // R4: enable, control, odd address, unused offset
        step(1'b1, 1'b0, base + 16'h2, 16'h0521, 4'h0);
        rd_chk("R4 enable", base + 16'h2, 16'h0521);
        rd_chk("R4 odd address", base + 16'h3, 16'h0521);
        step(1'b1, 1'b0, base + 16'h4, 16'hA5A5, 4'h0);
        rd_chk("R4 control", base + 16'h4, 16'hA5A5);
        step(1'b1, 1'b0, base + 16'h8, 16'h1234, 4'h0);
        rd_chk("R4 unused offset", base + 16'h8, 16'h0);

        // R2/R5/R6: each event in turn
        step(1'b0, 1'b0, 16'h0, 16'h0, 4'b0001);
        rd_chk("R2 timer status", base, 16'h0001);
        step(1'b0, 1'b0, 16'h0, 16'h0, 4'b1110);
        rd_chk("R2 all status", base, 16'h0521);
        // R3: write zero no effect, W1C, set wins over clear
        step(1'b1, 1'b0, base, 16'h0000, 4'h0);
        rd_chk("R3 zero write", base, 16'h0521);
        step(1'b1, 1'b0, base, 16'h0500, 4'h0);
        rd_chk("R3 clear", base, 16'h0021);
        step(1'b1, 1'b0, base, 16'h0021, 4'b0001);
        rd_chk("R3 set wins", base, 16'h0001);
        step(1'b1, 1'b0, base, 16'h0001, 4'h0);
        chk("R5 sci falls", {15'h0, sci}, 16'h0);
        chk("R6 rearm", {15'h0, tmr_arm}, 16'h1);

        // Random phase
        for (int blk = 0; blk < 12; blk++) begin
            base = 16'($urandom) & 16'hFFC0;
            cfg_base_word = {16'($urandom), base | 16'($urandom_range(0, 63))};
            cfg_enable_byte = 8'($urandom) | ((blk % 4 != 3) ? 8'h01 : 8'h00);
            for (int i = 0; i < 40; i++) begin
                logic [15:0] a;
                logic [15:0] wd;
                int unsigned pick;
                pick = $urandom_range(0, 9);
                if (pick < 7) a = base + 16'($urandom_range(0, 7));
                else if (pick == 7) a = base + 16'($urandom_range(8, 63));
                else a = 16'($urandom);
                wd = ($urandom_range(0, 1) == 1) ? 16'($urandom) : (16'($urandom) & MASK);
                step(1'($urandom), 1'($urandom), a, wd, 4'($urandom_range(0, 15)) &
                     (($urandom_range(0, 2) == 0) ? 4'hF : 4'h0));
            end
        end
        finish_run();
    end
endmodule